// File: doc/BRIEF.md
# Zero-Overhead Loop Micro-Sequencer

This block steps through a small program memory of wide control words and hands the user-control field of the current word to a data path that it does not itself contain. It has no ALU. Flow control comes from three instruction kinds and from one set of context registers: a remaining-pass count, a loop-end address and a loop-back address. When the program counter reaches the stored end address while the count is nonzero, the next address is the stored back address. No branch instruction is executed and no cycle is lost.

A counted-loop instruction and a call instruction both save the active context on a push/pop stack and load a new one. A call stores a count of one and a back address of the word after the call. Reaching the end of the called passage therefore returns without any return instruction, and the saved context comes back on that final pass. The program memory is written through a simple load port, normally while reset is held. A conditional jump tests the external condition input.

Top module: `zls_sequencer`

## Requirements
- R1: While reset is held and after its release before the next clock edge, `pc_o` is 4, `overflow_o` is 0 and `ctrl_o` equals bits [7:0] of program word 4.
- R2: A word is split as opcode [35:34] (0 no-op, 1 counted loop, 2 conditional jump, 3 call), address A [33:27], address B [26:20], count [19:8] and user control [7:0]. A no-op advances the PC by one, and `ctrl_o` always shows the user field of the word at the current `pc_o`.
- R3: A conditional jump moves the PC to A when `cond_i` is 1 and to PC+1 when it is 0.
- R4: A counted loop with count C (C ≥ 1), back address A and end address B runs the passage from A to B exactly C+1 times. Every pass costs only its own words, with no extra cycles.
- R5: A counted loop with count 0 acts as a no-op: the passage runs once and no context is saved.
- R6: A call jumps to A. After the word at end address B executes, the PC goes to the call address plus one, with no return instruction.
- R7: Loops nest. Finishing an inner loop restores the enclosing loop's count, end and back addresses, and the enclosing loop keeps counting.
- R8: At an active end address (count ≠ 0) the loop-back takes priority over the flow effect of the word stored there. On the final pass, when the saved context is active again, that word's own flow applies.
- R9: A loop or call that must save a context while the stack is full sets `overflow_o`. `overflow_o` stays set, and `pc_o` and `ctrl_o` stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 1 | External condition tested by conditional jumps |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | 7 | Program memory write address |
| prog_data_i | input | 36 | Program word to write |
| pc_o | output | 7 | Current program counter |
| ctrl_o | output | 8 | User control field of the word at `pc_o` |
| overflow_o | output | 1 | Sticky stack overflow, sequencing halted |

## Verification
The embedded properties watch every cycle for the following:
- a taken loop-back landing on the stored back address;
- a taken jump landing on A;
- a call installing its return address;
- a halted sequencer holding its PC and flag;
- the stack pointer staying within depth and never receiving a push when full.

Only the bench's scenarios can show the rest, by comparing pass counts and cycle totals against arithmetic:
- that a count C yields exactly C+1 passes;
- that count 0 saves nothing;
- that nested contexts come back in the right order;
- that the end-address priority changes the observable trace.

// File: rtl/zls_pkg.sv
package zls_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_FOR   = 2'd1,
    OP_JMPIF = 2'd2,
    OP_CALL  = 2'd3
  } zls_op_t;
endpackage

// File: rtl/zls_progmem.sv
module zls_progmem #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 36,
  parameter int USER_W = 8
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          flow_addr,
  output logic [WORD_W-USER_W-1:0]   flow_word,
  input  logic [ADDR_W-1:0]          user_addr,
  output logic [USER_W-1:0]          user_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Two asynchronous read ports: decode side and look-ahead for the control output
  assign flow_word = mem[flow_addr][WORD_W-1:USER_W];
  assign user_word = mem[user_addr][USER_W-1:0];
endmodule

// File: rtl/zls_ctx_stack.sv
module zls_ctx_stack #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 12,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              dec,
  input  logic [CNT_W-1:0]  new_cnt,
  input  logic [ADDR_W-1:0] new_end,
  input  logic [ADDR_W-1:0] new_back,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] back_a,
  output logic              full
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW  = CNT_W + 2 * ADDR_W;
  localparam logic [SPW-1:0] SP_MAX = SPW'(DEPTH);

  logic [EW-1:0]  stk [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_m1;
  logic [IXW-1:0] wr_ix, rd_ix;
  logic           empty;

  assign sp_m1 = sp - SPW'(1);
  assign wr_ix = sp[IXW-1:0];
  assign rd_ix = sp_m1[IXW-1:0];
  assign empty = (sp == '0);
  assign full  = (sp == SP_MAX);

  always_ff @(posedge clk) begin
    if (push && !rst) stk[wr_ix] <= {cnt, end_a, back_a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp     <= '0;
      cnt    <= '0;
      end_a  <= '0;
      back_a <= '0;
    end else if (push) begin
      sp     <= sp + SPW'(1);
      cnt    <= new_cnt;
      end_a  <= new_end;
      back_a <= new_back;
    end else if (pop) begin
      if (empty) begin
        cnt    <= '0;
        end_a  <= '0;
        back_a <= '0;
      end else begin
        {cnt, end_a, back_a} <= stk[rd_ix];
        sp <= sp_m1;
      end
    end else if (dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_sp_bound_r9: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_MAX);
  p_push_room_r9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_single_op_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({push, pop, dec}) <= 1);
endmodule

// File: rtl/zls_sequencer.sv
module zls_sequencer
  import zls_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int CNT_W       = 12,
  parameter int USER_W      = 8,
  parameter int STACK_DEPTH = 128,
  parameter int START_ADDR  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cond_i,
  input  logic                                  prog_we_i,
  input  logic [ADDR_W-1:0]                     prog_addr_i,
  input  logic [2+2*ADDR_W+CNT_W+USER_W-1:0]    prog_data_i,
  output logic [ADDR_W-1:0]                     pc_o,
  output logic [USER_W-1:0]                     ctrl_o,
  output logic                                  overflow_o
);
  localparam int WORD_W = 2 + 2 * ADDR_W + CNT_W + USER_W;
  localparam int FLOW_W = WORD_W - USER_W;
  localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0] pc_q, pc_n, pc_inc;
  logic [USER_W-1:0] ctrl_q, user_n;
  logic              halt_q, ovf_set;
  logic [FLOW_W-1:0] flow;
  zls_op_t           op;
  logic [ADDR_W-1:0] fa, fb;
  logic [CNT_W-1:0]  fc;

  logic              push, pop, dec, full;
  logic [CNT_W-1:0]  new_cnt, cnt;
  logic [ADDR_W-1:0] new_end, new_back, end_a, back_a;
  logic              at_end;

  zls_progmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .USER_W(USER_W)) u_mem (
    .clk       (clk),
    .we        (prog_we_i),
    .waddr     (prog_addr_i),
    .wdata     (prog_data_i),
    .flow_addr (pc_q),
    .flow_word (flow),
    .user_addr (pc_n),
    .user_word (user_n)
  );

  zls_ctx_stack #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(STACK_DEPTH)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .dec      (dec),
    .new_cnt  (new_cnt),
    .new_end  (new_end),
    .new_back (new_back),
    .cnt      (cnt),
    .end_a    (end_a),
    .back_a   (back_a),
    .full     (full)
  );

  // Field split of the flow part of the word
  assign op     = zls_op_t'(flow[FLOW_W-1 -: 2]);
  assign fa     = flow[FLOW_W-3 -: ADDR_W];
  assign fb     = flow[FLOW_W-3-ADDR_W -: ADDR_W];
  assign fc     = flow[CNT_W-1:0];
  assign pc_inc = pc_q + ADDR_W'(1);
  assign at_end = (cnt != '0) && (pc_q == end_a);

  always_comb begin
    pc_n     = pc_inc;
    push     = 1'b0;
    pop      = 1'b0;
    dec      = 1'b0;
    ovf_set  = 1'b0;
    new_cnt  = '0;
    new_end  = '0;
    new_back = '0;
    if (rst) begin
      pc_n = START;
    end else if (halt_q) begin
      pc_n = pc_q;
    end else if (at_end) begin
      pc_n = back_a;
      if (cnt == CNT_W'(1)) pop = 1'b1;
      else                  dec = 1'b1;
    end else begin
      unique case (op)
        OP_FOR: begin
          if (fc != '0) begin
            if (full) begin
              ovf_set = 1'b1;
              pc_n    = pc_q;
            end else begin
              push     = 1'b1;
              new_cnt  = fc;
              new_end  = fb;
              new_back = fa;
            end
          end
        end
        OP_JMPIF: if (cond_i) pc_n = fa;
        OP_CALL: begin
          if (full) begin
            ovf_set = 1'b1;
            pc_n    = pc_q;
          end else begin
            push     = 1'b1;
            new_cnt  = CNT_W'(1);
            new_end  = fb;
            new_back = pc_inc;
            pc_n     = fa;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    pc_q   <= pc_n;
    ctrl_q <= user_n;
    if (rst)          halt_q <= 1'b0;
    else if (ovf_set) halt_q <= 1'b1;
  end

  assign pc_o       = pc_q;
  assign ctrl_o     = ctrl_q;
  assign overflow_o = halt_q;

  p_loopback_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(at_end) && !$past(halt_q)) |-> (pc_q == $past(back_a)));
  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_JMPIF) && $past(cond_i) && !$past(at_end)
     && !$past(halt_q)) |-> (pc_q == $past(fa)));
  p_call_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_CALL) && !$past(at_end) && !$past(halt_q)
     && !$past(full)) |-> (pc_q == $past(fa) && back_a == $past(pc_q) + ADDR_W'(1)));
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(halt_q)) |-> (halt_q && $stable(pc_q) && $stable(ctrl_q)));
endmodule

// File: tb/zls_sequencer_test.sv
module zls_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cond = 1'b0;
  logic        prog_we = 1'b0;
  logic [6:0]  prog_addr = '0;
  logic [35:0] prog_data = '0;
  logic [6:0]  pc;
  logic [7:0]  ctrl;
  logic        ovf;
  int          nchk = 0;
  int          nfail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  zls_sequencer #(.STACK_DEPTH(2)) uut (
    .clk(clk), .rst(rst), .cond_i(cond), .prog_we_i(prog_we),
    .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .pc_o(pc), .ctrl_o(ctrl), .overflow_o(ovf)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog (R1..all) actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [35:0] mk(int op, int a, int b, int c, int u);
    return {2'(op), 7'(a), 7'(b), 12'(c), 8'(u)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [35:0] w);
    prog_we = 1'b1; prog_addr = 7'(a); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic clear_prog();
    rst = 1'b1;
    for (int a = 0; a < 128; a++) put(a, 36'd0);
  endtask

  task automatic launch();
    prog_we = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    @(negedge clk);

    // R1, R2: straight no-op run, control field follows pc
    clear_prog();
    for (int a = 4; a < 10; a++) put(a, mk(0, 0, 0, 0, a * 7 + 3));
    put(10, mk(2, 10, 0, 0, 8'h5A));
    cond = 1'b1;
    launch();
    chk(pc == 7'd4, "R1 pc", pc, 4);
    chk(ctrl == 8'd31, "R1 ctrl", ctrl, 31);
    chk(ovf == 1'b0, "R1 overflow", ovf, 0);
    for (int k = 1; k <= 7; k++) begin
      int ep;
      step();
      ep = (4 + k > 10) ? 10 : 4 + k;
      chk(pc == 7'(ep), "R2 pc", pc, ep);
      chk(ctrl == ((ep == 10) ? 8'h5A : 8'(ep * 7 + 3)), "R2 ctrl", ctrl,
          (ep == 10) ? 90 : ep * 7 + 3);
    end

    // R3: conditional jump, sweep of targets and both condition values
    for (int t = 0; t < 128; t += 9) begin
      for (int cb = 0; cb < 2; cb++) begin
        clear_prog();
        put(4, mk(2, t, 0, 0, 0));
        cond = cb[0];
        launch();
        step();
        chk(pc == 7'(cb ? t : 5), "R3 jump", pc, cb ? t : 5);
      end
    end

    // R4, R5, R8: counted loop sweep; end word holds a taken jump
    for (int i = 0; i < 11; i++) begin
      int c, passes, cycles, hits;
      c = (i == 10) ? 4095 : i;
      clear_prog();
      put(4, mk(1, 5, 6, c, 1));
      put(5, mk(0, 0, 0, 0, 8'h11));
      put(6, mk(2, 9, 0, 0, 8'h22));
      put(9, mk(2, 9, 0, 0, 8'h33));
      cond = 1'b1;
      launch();
      cycles = 0; hits = 0;
      while (pc != 7'd9 && cycles < 10000) begin
        step();
        cycles++;
        if (pc == 7'd5) begin
          hits++;
          if (hits == 1) chk(ctrl == 8'h11, "R2 ctrl in loop", ctrl, 17);
        end
      end
      passes = (c == 0) ? 1 : c + 1;
      chk(hits == passes, (c == 0) ? "R5 passes" : "R4 R8 passes", hits, passes);
      chk(cycles == 1 + 2 * passes, (c == 0) ? "R5 cycles" : "R4 cycles", cycles,
          1 + 2 * passes);
    end

    // R6: call returns to the word after the call
    begin
      int exp_tr[6] = '{40, 41, 42, 5, 6, 6};
      clear_prog();
      put(4, mk(3, 40, 42, 0, 1));
      put(5, mk(0, 0, 0, 0, 8'h77));
      put(6, mk(2, 6, 0, 0, 0));
      cond = 1'b1;
      launch();
      for (int k = 0; k < 6; k++) begin
        step();
        chk(pc == 7'(exp_tr[k]), "R6 trace", pc, exp_tr[k]);
        if (exp_tr[k] == 5) chk(ctrl == 8'h77, "R6 ctrl after return", ctrl, 119);
      end
    end

    // R9: call overflow with a two-entry stack
    clear_prog();
    put(4, mk(3, 10, 12, 0, 1));
    put(10, mk(3, 20, 22, 0, 2));
    put(20, mk(3, 30, 32, 0, 3));
    launch();
    step(); step();
    chk(pc == 7'd20 && ovf == 1'b0, "R9 before overflow", {ovf, pc}, 20);
    step();
    chk(ovf == 1'b1, "R9 overflow set", ovf, 1);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(pc == 7'd20 && ovf == 1'b1 && ctrl == 8'd3, "R9 frozen", pc, 20);
    end

    // R9: loop overflow
    clear_prog();
    put(4, mk(1, 10, 20, 1, 0));
    put(5, mk(1, 10, 20, 1, 0));
    put(6, mk(1, 10, 20, 1, 9));
    launch();
    chk(ovf == 1'b0, "R1 R9 overflow cleared by reset", ovf, 0);
    step(); step(); step();
    chk(pc == 7'd6 && ovf == 1'b1, "R9 loop overflow", {ovf, pc}, 134);
    step();
    chk(pc == 7'd6 && ctrl == 8'd9, "R9 loop frozen", pc, 6);

    // R7: nested loops, outer 3 passes, inner 2 passes each
    begin
      int cycles, h5, h6, h8;
      clear_prog();
      put(4, mk(1, 5, 8, 2, 0));
      put(5, mk(1, 6, 7, 1, 0));
      put(9, mk(2, 9, 0, 0, 0));
      cond = 1'b1;
      launch();
      cycles = 0; h5 = 0; h6 = 0; h8 = 0;
      while (pc != 7'd9 && cycles < 1000) begin
        step();
        cycles++;
        if (pc == 7'd5) h5++;
        if (pc == 7'd6) h6++;
        if (pc == 7'd8) h8++;
      end
      chk(cycles == 19, "R7 cycles", cycles, 19);
      chk(h5 == 3, "R7 outer passes", h5, 3);
      chk(h6 == 6, "R7 inner passes", h6, 6);
      chk(h8 == 3, "R7 outer end visits", h8, 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule